// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Option

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be one shared clock or two unrelated clocks. The write and read pointers cross between the domains as Gray codes through two-flop synchronizers. Full and the write-side flags are computed in the write domain. Empty and almost-empty are computed in the read domain.

A static mode input selects how the read port behaves. In standard timing, a word reaches the data output only when a read is requested. In fall-through timing, the oldest word is moved onto the output on its own. The read-side status pin then means "output holds a word" rather than "buffer empty", and the write-side status pin means "room for input" rather than "buffer full".

The almost-empty and almost-full thresholds come from two offset registers. These registers are loaded through the ordinary write port while a load control is held high. An output-enable input gates the read data.

Top module: `dcf_fwft_fifo`

## Requirements
- R1: While `load_en` is low, a rising write-clock edge with `wr_en` high and the buffer not full stores `wr_data`. Words leave the buffer in the order they were stored.
- R2: Standard mode (`fwft_mode`=0): a rising read-clock edge with `rd_en` high and the buffer not empty places the oldest word on `rd_data` after that edge. In this mode `rd_flag`=1 means empty.
- R3: Fall-through mode (`fwft_mode`=1): a word written into an empty buffer appears on `rd_data` after the third rising read-clock edge that follows the write, with no `rd_enable`. In this mode `rd_flag`=1 means the output holds a word. `rd_en` consumes that word and brings in the next one, and the word is held while `rd_en` is low.
- R4: `wr_flag`=1 means full when `fwft_mode`=0 (DEPTH words held). When `fwft_mode`=1, `wr_flag`=1 means input ready, which is the inverse of full.
- R5: A write while full and a standard-mode read while empty are ignored. Neither the stored data, the order nor `rd_data` change.
- R6: `half_full` is 1 when the write-side word count exceeds DEPTH/2.
- R7: `almost_empty` is 1 when the read-side word count is at or below the empty offset.
- R8: `almost_full` is 1 when the free space (DEPTH minus the write-side count) is at or below the full offset.
- R9: With `load_en` high, each write-enabled write-clock edge loads `wr_data[CW-1:0]` into an offset register instead of storing a word, where CW = log2(DEPTH)+1. The first such edge loads the empty offset, the second loads the full offset, and the sequence then wraps back to the empty offset.
- R10: A synchronous active-high `rst` empties the buffer and sets both offsets to 7. It also returns the load sequence to the empty offset.
- R11: When `out_en` is 0, `rd_data` is all zeros. When `out_en` is 1, `rd_data` carries the output register.
- R12: Each pointer changes by one Gray-code bit per edge. The empty status clears two read-clock edges after the write edge that fills an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| fwft_mode | input | 1 | 0 = standard timing, 1 = fall-through timing (static) |
| wr_en | input | 1 | Write enable |
| load_en | input | 1 | Route write-enabled words to the offset registers |
| wr_data | input | 18 | Write data, or offset value in its low bits |
| rd_en | input | 1 | Read enable |
| out_en | input | 1 | Output enable for read data |
| rd_data | output | 18 | Read data, zero when output is disabled |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half of the entries in use |
| almost_empty | output | 1 | Read-side count at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The bench builds the block with DEPTH set to 16. At that size, filling to full, crossing the half mark and both default thresholds of 7 takes only a few dozen cycles, and a fill table can list every step. Both clock pins share one clock, so the two-stage pointer crossing has a fixed latency. This lets the bench check the empty release and the fall-through delay at exact edges. Loaded offsets of 1 and 12 move both thresholds away from their defaults. Restoring the defaults on reset can then be observed at the flags.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DATA_W_DEF   = 18;
    localparam int DEPTH_DEF    = 1024;
    localparam int OFFSET_DEF   = 7;
    localparam int SYNC_STAGES  = 2;

    // Read-port timing selection
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Which offset register the next load-write targets
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;

    // Write-domain status bundle
    typedef struct packed {
        logic full;
        logic half;
        logic afull;
    } wr_status_t;

endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
    parameter int W      = 11,
    parameter int STAGES = dcf_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    // Gray to binary on the last stage
    always_comb begin
        logic [W-1:0] b;
        b[W-1] = stg[STAGES-1][W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ stg[STAGES-1][i];
        end
        bin_out = b;
    end

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = dcf_pkg::DATA_W_DEF,
    parameter int DEPTH  = dcf_pkg::DEPTH_DEF,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] rbin_s,
    output logic [CW-1:0] wgray,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output wr_status_t    status,
    output logic [CW-1:0] ae_off
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] OFS_C   = CW'(OFFSET_DEF);

    logic [CW-1:0] wbin, wbin_nxt, wcount, af_off;
    logic          full, push, load_hit;
    ofs_sel_e      sel;

    assign wcount   = wbin - rbin_s;
    assign full     = (wcount == DEPTH_C);
    assign push     = wr_en && !load_en && !full;
    assign load_hit = wr_en && load_en;
    assign wbin_nxt = wbin + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            sel    <= SEL_EMPTY_OFS;
            ae_off <= OFS_C;
            af_off <= OFS_C;
        end else begin
            if (push) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            end
            if (load_hit) begin
                if (sel == SEL_EMPTY_OFS) begin
                    ae_off <= load_val;
                    sel    <= SEL_FULL_OFS;
                end else begin
                    af_off <= load_val;
                    sel    <= SEL_EMPTY_OFS;
                end
            end
        end
    end

    assign mem_we       = push;
    assign waddr        = wbin[AW-1:0];
    assign status.full  = full;
    assign status.half  = (wcount > HALF_C);
    assign status.afull = ((DEPTH_C - wcount) <= af_off);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        wcount <= DEPTH_C);
    assert_full_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        full && wr_en |=> $stable(wbin));
    assert_load_not_stored_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en && load_en |=> $stable(wbin));
    assert_wr_gray_step_R12: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    assert_full_implies_flags_R6: assert property (@(posedge clk) disable iff (rst)
        status.full |-> status.half && status.afull);

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_mode_e          mode,
    input  logic              rd_en,
    input  logic [CW-1:0]     wbin_s,
    input  logic [CW-1:0]     ae_off,
    input  logic [DATA_W-1:0] mem_q,
    output logic [AW-1:0]     raddr,
    output logic [CW-1:0]     rgray,
    output logic [DATA_W-1:0] q_data,
    output logic              q_valid,
    output logic              core_empty,
    output logic              almost_empty
);

    localparam logic [CW:0] LIMIT_C = (CW+1)'(DEPTH + 1);

    logic [CW-1:0] rbin, rbin_nxt;
    logic [CW:0]   rcount;
    logic          pop, fwft;

    assign fwft       = (mode == MODE_FWFT);
    assign core_empty = (rbin == wbin_s);
    assign pop        = !core_empty && (fwft ? (!q_valid || rd_en) : rd_en);
    assign rbin_nxt   = rbin + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            q_data  <= '0;
            q_valid <= 1'b0;
        end else if (pop) begin
            rbin    <= rbin_nxt;
            rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
            q_data  <= mem_q;
            q_valid <= 1'b1;
        end else if (rd_en && core_empty) begin
            q_valid <= 1'b0;
        end
    end

    assign raddr        = rbin[AW-1:0];
    assign rcount       = {1'b0, wbin_s - rbin} + {{CW{1'b0}}, fwft && q_valid};
    assign almost_empty = (rcount <= {1'b0, ae_off});

    assert_empty_read_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        !fwft && core_empty && rd_en |=> $stable(rbin) && $stable(q_data));
    assert_fwft_hold_R3: assert property (@(posedge clk) disable iff (rst)
        fwft && q_valid && !rd_en |=> q_valid && $stable(q_data));
    assert_rd_gray_step_R12: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
    assert_rd_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        rcount <= LIMIT_C);

endmodule

// File: rtl/dcf_fwft_fifo.sv
module dcf_fwft_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              fwft_mode,
    input  logic              wr_en,
    input  logic              load_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);

    rd_mode_e          mode;
    wr_status_t        wstat;
    logic [CW-1:0]     wgray, rgray, wbin_s, rbin_s, ae_off;
    logic [AW-1:0]     waddr, raddr;
    logic              mem_we, q_valid, core_empty;
    logic [DATA_W-1:0] mem_q, q_data;

    assign mode = rd_mode_e'(fwft_mode);

    dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk      (wr_clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .load_en  (load_en),
        .load_val (wr_data[CW-1:0]),
        .rbin_s   (rbin_s),
        .wgray    (wgray),
        .mem_we   (mem_we),
        .waddr    (waddr),
        .status   (wstat),
        .ae_off   (ae_off)
    );

    dcf_gray_sync #(.W(CW)) u_sync_w2r (
        .clk     (rd_clk),
        .rst     (rst),
        .gray_in (wgray),
        .bin_out (wbin_s)
    );

    dcf_gray_sync #(.W(CW)) u_sync_r2w (
        .clk     (wr_clk),
        .rst     (rst),
        .gray_in (rgray),
        .bin_out (rbin_s)
    );

    dcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_q)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
        .clk          (rd_clk),
        .rst          (rst),
        .mode         (mode),
        .rd_en        (rd_en),
        .wbin_s       (wbin_s),
        .ae_off       (ae_off),
        .mem_q        (mem_q),
        .raddr        (raddr),
        .rgray        (rgray),
        .q_data       (q_data),
        .q_valid      (q_valid),
        .core_empty   (core_empty),
        .almost_empty (almost_empty)
    );

    assign rd_flag     = (mode == MODE_FWFT) ? q_valid : core_empty;
    assign wr_flag     = (mode == MODE_FWFT) ? !wstat.full : wstat.full;
    assign half_full   = wstat.half;
    assign almost_full = wstat.afull;
    assign rd_data     = out_en ? q_data : '0;

endmodule

// File: tb/tb_dcf_fwft_fifo.sv
module tb_dcf_fwft_fifo;

    localparam int DW = 18;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst, fwft_mode, wr_en, load_en, rd_en, out_en;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_flag, wr_flag, half_full, almost_empty, almost_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dcf_fwft_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .load_en(load_en), .wr_data(wr_data),
        .rd_en(rd_en), .out_en(out_en), .rd_data(rd_data),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // {data[20:3], exp_full, exp_half_full, exp_almost_full} after each fill write
    localparam logic [20:0] FILL_VEC [16] = '{
        {18'h00001, 3'b000}, {18'h00012, 3'b000}, {18'h00123, 3'b000}, {18'h01234, 3'b000},
        {18'h12345, 3'b000}, {18'h2A5A5, 3'b000}, {18'h15A5A, 3'b000}, {18'h3C3C3, 3'b000},
        {18'h03C3C, 3'b011}, {18'h0F0F0, 3'b011}, {18'h30F0F, 3'b011}, {18'h2AAAA, 3'b011},
        {18'h15555, 3'b011}, {18'h00800, 3'b011}, {18'h3F00F, 3'b011}, {18'h1E1E1, 3'b111}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        fwft_mode = mode;
        rst = 1'b1; wr_en = 1'b0; load_en = 1'b0; rd_en = 1'b0;
        out_en = 1'b1; wr_data = '0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // ---- reset state, standard mode (R10, R4)
        do_reset(1'b0);
        check("R10 empty after reset", rd_flag, 1);
        check("R4 full low after reset", wr_flag, 0);
        check("R6 half_full after reset", half_full, 0);
        check("R7 almost_empty after reset", almost_empty, 1);
        check("R8 almost_full after reset", almost_full, 0);

        // ---- table-driven fill (R1, R4, R6, R8)
        for (int i = 0; i < 16; i++) begin
            wr_en = 1'b1; wr_data = FILL_VEC[i][20:3];
            tick(1);
            check("R4 full during fill", wr_flag, FILL_VEC[i][2]);
            check("R6 half_full during fill", half_full, FILL_VEC[i][1]);
            check("R8 almost_full during fill", almost_full, FILL_VEC[i][0]);
        end
        // write while full is ignored (R5)
        wr_data = 18'h3FFFF;
        tick(1);
        wr_en = 1'b0;
        check("R5 still full after extra write", wr_flag, 1);
        tick(2);
        check("R2 not empty when filled", rd_flag, 0);
        check("R7 almost_empty low when filled", almost_empty, 0);

        // ---- drain in order (R1, R2, R7 with default offset)
        rd_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            tick(1);
            check("R1 order / R2 read data", rd_data, FILL_VEC[k][20:3]);
            check("R7 almost_empty during drain", almost_empty, ((15 - k) <= 7) ? 1 : 0);
            check("R2 empty flag during drain", rd_flag, (k == 15) ? 1 : 0);
        end
        tick(1);
        check("R5 read while empty ignored", rd_data, 18'h1E1E1);
        rd_en = 1'b0;
        tick(2);
        check("R4 full cleared after drain", wr_flag, 0);
        check("R6 half_full cleared after drain", half_full, 0);

        // ---- empty release latency (R12)
        do_reset(1'b0);
        write_word(18'h00ABC);
        check("R12 empty right after write", rd_flag, 1);
        tick(1);
        check("R12 empty one edge later", rd_flag, 1);
        tick(1);
        check("R12 empty clears two edges later", rd_flag, 0);
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        check("R2 single word read", rd_data, 18'h00ABC);

        // ---- offset loading with wrap (R9, R8)
        do_reset(1'b0);
        load_en = 1'b1; wr_en = 1'b1;
        wr_data = 18'd3;  tick(1);
        wr_data = 18'd12; tick(1);
        wr_data = 18'd1;  tick(1);
        wr_en = 1'b0; load_en = 1'b0;
        tick(3);
        check("R9 loaded words not stored", rd_flag, 1);
        write_word(18'h00111);
        tick(2);
        check("R9 wrapped empty offset 1, count 1", almost_empty, 1);
        check("R8 full offset 12, count 1", almost_full, 0);
        write_word(18'h00222);
        tick(2);
        check("R9 wrapped empty offset 1, count 2", almost_empty, 0);
        write_word(18'h00333);
        check("R8 full offset 12, count 3", almost_full, 0);
        write_word(18'h00444);
        check("R8 full offset 12, count 4", almost_full, 1);
        check("R6 half_full at count 4", half_full, 0);

        // ---- reset mid-use restores defaults (R10)
        do_reset(1'b0);
        check("R10 empty after second reset", rd_flag, 1);
        check("R10 almost_full after second reset", almost_full, 0);
        for (int i = 0; i < 4; i++) write_word(18'h00050 + 18'(i));
        check("R10 default full offset restored, count 4", almost_full, 0);
        for (int i = 0; i < 5; i++) write_word(18'h00060 + 18'(i));
        check("R10 default full offset 7, count 9", almost_full, 1);
        tick(2);
        check("R10 default empty offset 7, count 9", almost_empty, 0);

        // ---- fall-through mode (R3, R4, R11)
        do_reset(1'b1);
        check("R3 output not ready after reset", rd_flag, 0);
        check("R4 input ready after reset", wr_flag, 1);
        write_word(18'h0AAAA);
        check("R3 not ready after write edge", rd_flag, 0);
        tick(1);
        check("R3 not ready one edge later", rd_flag, 0);
        tick(1);
        check("R3 not ready two edges later", rd_flag, 0);
        tick(1);
        check("R3 ready three edges later", rd_flag, 1);
        check("R3 first word fell through", rd_data, 18'h0AAAA);
        out_en = 1'b0; #1;
        check("R11 output disabled reads zero", rd_data, 0);
        out_en = 1'b1; #1;
        check("R11 output re-enabled", rd_data, 18'h0AAAA);
        write_word(18'h0BBBB);
        write_word(18'h0CCCC);
        tick(3);
        check("R3 word held without rd_en", rd_data, 18'h0AAAA);
        rd_en = 1'b1;
        tick(1);
        check("R3 rd_en advances to second", rd_data, 18'h0BBBB);
        tick(1);
        check("R3 rd_en advances to third", rd_data, 18'h0CCCC);
        check("R3 ready with last word", rd_flag, 1);
        tick(1);
        check("R3 ready drops after last word taken", rd_flag, 0);
        rd_en = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule